// File: doc/BRIEF.md
# Transmit Pause and Line-Hold Controller

This block sits between a serial transmitter's shift stage and the line. When the framing logic upstream decodes a delay command from the outgoing data stream, it presents that command here as a one-cycle strobe. The strobe carries a delay count and a hold level. The controller then raises a stall towards the transmitter and forces the line to the chosen level. A level of 0 sends a break and a level of 1 sends an idle fill. The line stays forced until the requested number of ticks has elapsed, and then the transmitter's own serial bit reaches the line again.

Delay commands act only while the command-enable input is high. One further command may arrive during an active delay. It is parked in a single pending slot and starts the moment the current delay expires, so the stall stays high without a gap between the two delays.

The control core has two states. `ST_IDLE` means no delay is running and `ST_HOLD` means a delay is counting. Each cycle the core picks one named transition:
- `TR_STAY` stays idle.
- `TR_SKIP` takes a zero-length command while idle.
- `TR_START` goes from idle to hold.
- `TR_COUNT` stays in hold, with or without a decrement.
- `TR_CHAIN` reloads from the next command at expiry and stays in hold.
- `TR_DONE` goes from hold back to idle.

Top module: `tx_pause_ctrl`

## Requirements
- R1: A command strobe seen while `cmd_en` is 0 has no effect. The stall and the line are unchanged, both when idle and during an active delay.
- R2: An enabled command with a nonzero delay D, accepted while idle, raises `tx_stall` in the first cycle after the strobe.
- R3: `tx_stall` stays high until D ticks have been counted. It is low from the cycle after the clock edge that counts the D-th tick.
- R4: While `tx_stall` is high, `line_out` equals the hold level of the running command: 0 when `cmd_fill` was 0 (break) and 1 when it was 1 (fill).
- R5: One tick removes one unit of delay. A tick in the same cycle as an accepted command is not counted, and cycles without a tick do not count.
- R6: An enabled command with delay 0 completes at once. No stall cycle is produced.
- R7: An enabled command arriving during an active delay waits and starts when that delay ends. The stall stays high through the hand-over, and the line takes the new command's level. A waiting command with delay 0 ends the stall normally.
- R8: Only one command can wait. Further commands that arrive while one is already waiting are dropped.
- R9: While `tx_stall` is low, `line_out` equals `tx_bit`.
- R10: During and after reset, `tx_stall` is 0 and the line passes `tx_bit`.
- R11: Dropping `cmd_en` during an active delay does not shorten or abort that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Enables acceptance of delay commands |
| cmd_valid | input | 1 | One-cycle strobe of a decoded delay command |
| cmd_delay | input | DW | Delay length in ticks |
| cmd_fill | input | 1 | Hold level: 0 break, 1 fill |
| tick | input | 1 | Delay time base, one pulse per unit |
| tx_bit | input | 1 | Serial bit from the transmitter |
| line_out | output | 1 | Line after the hold multiplexer |
| tx_stall | output | 1 | Pauses the transmitter while a delay runs |

## Verification
The assertions assume that `cmd_valid` is a clean single-cycle strobe with its delay and level stable in that cycle. They also assume that `tick` is a synchronous pulse in the clock domain, so the down-counter never sees a decrement at zero. The stimulus drives every input at the falling edge from a single sequencing process, with commands and ticks only in whole clock cycles. It sweeps delays from 0 to 6 under tick rates of one per one, two and three cycles. It places follow-on commands only inside active delays, so the cases of a waiting command and a dropped command arise exactly where intended.

// File: rtl/tx_pause_pkg.sv
package tx_pause_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pause_state_t;

    typedef enum logic [2:0] {
        TR_STAY  = 3'd0,
        TR_SKIP  = 3'd1,
        TR_START = 3'd2,
        TR_COUNT = 3'd3,
        TR_CHAIN = 3'd4,
        TR_DONE  = 3'd5
    } pause_trans_t;

    typedef enum logic {
        LVL_BREAK = 1'b0,
        LVL_FILL  = 1'b1
    } hold_lvl_t;

endpackage

// File: rtl/tx_pause_cnt.sv
module tx_pause_cnt #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          dec,
    output logic [DW-1:0] cnt,
    output logic          last
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

    // R3: the count never wraps below zero
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

endmodule

// File: rtl/tx_pause_pend.sv
import tx_pause_pkg::*;

module tx_pause_pend #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          take,
    input  logic [DW-1:0] cap_delay,
    input  hold_lvl_t     cap_lvl,
    output logic          full,
    output logic [DW-1:0] p_delay,
    output hold_lvl_t     p_lvl
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            p_delay <= '0;
            p_lvl   <= LVL_FILL;
        end else if (take) begin
            full    <= 1'b0;
        end else if (cap && !full) begin
            full    <= 1'b1;
            p_delay <= cap_delay;
            p_lvl   <= cap_lvl;
        end
    end

    // R8: a waiting command is never replaced by a later one
    a_r8_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(p_delay) && $stable(p_lvl)));

endmodule

// File: rtl/tx_pause_fsm.sv
import tx_pause_pkg::*;

module tx_pause_fsm #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [DW-1:0] cmd_delay,
    input  hold_lvl_t     cmd_lvl,
    input  logic          tick,
    input  logic [DW-1:0] cnt,
    input  logic          cnt_last,
    input  logic          pend_full,
    input  logic [DW-1:0] pend_delay,
    input  hold_lvl_t     pend_lvl,
    input  logic          tx_bit,
    output logic          cnt_load,
    output logic [DW-1:0] cnt_val,
    output logic          cnt_dec,
    output logic          pend_cap,
    output logic          pend_take,
    output logic          hold,
    output logic          line
);
    pause_state_t state_q, state_d;
    pause_trans_t trans;
    hold_lvl_t    lvl_q, lvl_d;

    logic          src_valid;
    logic [DW-1:0] src_delay;
    hold_lvl_t     src_lvl;
    logic          expire;

    // Source of the next delay at expiry: waiting slot first, then a live strobe
    always_comb begin
        if (pend_full) begin
            src_valid = 1'b1;
            src_delay = pend_delay;
            src_lvl   = pend_lvl;
        end else begin
            src_valid = acc;
            src_delay = cmd_delay;
            src_lvl   = cmd_lvl;
        end
    end

    assign expire = (state_q == ST_HOLD) && tick && cnt_last;

    // Transition selection
    always_comb begin
        trans = TR_STAY;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && (cmd_delay != '0))      trans = TR_START;
                else if (acc)                      trans = TR_SKIP;
                else                               trans = TR_STAY;
            end
            ST_HOLD: begin
                if (!expire)                       trans = TR_COUNT;
                else if (src_valid && (src_delay != '0)) trans = TR_CHAIN;
                else                               trans = TR_DONE;
            end
            default:                               trans = TR_STAY;
        endcase
    end

    // Actions per transition
    always_comb begin
        state_d   = state_q;
        lvl_d     = lvl_q;
        cnt_load  = 1'b0;
        cnt_val   = cmd_delay;
        cnt_dec   = 1'b0;
        pend_cap  = 1'b0;
        pend_take = 1'b0;
        unique case (trans)
            TR_STAY, TR_SKIP: begin
                state_d = ST_IDLE;
            end
            TR_START: begin
                state_d  = ST_HOLD;
                cnt_load = 1'b1;
                cnt_val  = cmd_delay;
                lvl_d    = cmd_lvl;
            end
            TR_COUNT: begin
                state_d  = ST_HOLD;
                cnt_dec  = tick;
                pend_cap = acc && !pend_full;
            end
            TR_CHAIN: begin
                state_d   = ST_HOLD;
                cnt_load  = 1'b1;
                cnt_val   = src_delay;
                lvl_d     = src_lvl;
                pend_take = pend_full;
            end
            TR_DONE: begin
                state_d   = ST_IDLE;
                pend_take = pend_full;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= LVL_FILL;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // Outputs
    always_comb begin
        hold = (state_q == ST_HOLD);
        line = hold ? lvl_q : tx_bit;
    end

    // R3: while holding, the delay counter is nonzero
    a_r3_hold_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (cnt != '0));

    // R5: a tick that does not expire the delay removes exactly one unit
    a_r5_one_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && tick && !cnt_last) |=> (hold && (cnt == $past(cnt) - DW'(1))));

    // R6: a zero-length command while idle never produces a stall
    a_r6_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && acc && (cmd_delay == '0)) |=> !hold);

    // R4: the held level cannot change before the running delay expires
    a_r4_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !(tick && cnt_last)) |=> (hold && $stable(line)));

    // R2: an accepted nonzero command from idle stalls on the next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && acc && (cmd_delay != '0)) |=> hold);

endmodule

// File: rtl/tx_pause_ctrl.sv
import tx_pause_pkg::*;

module tx_pause_ctrl #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_en,
    input  logic          cmd_valid,
    input  logic [DW-1:0] cmd_delay,
    input  logic          cmd_fill,
    input  logic          tick,
    input  logic          tx_bit,
    output logic          line_out,
    output logic          tx_stall
);
    logic          acc;
    hold_lvl_t     cmd_lvl;
    logic          cnt_load, cnt_dec, cnt_last;
    logic [DW-1:0] cnt_val, cnt;
    logic          pend_cap, pend_take, pend_full;
    logic [DW-1:0] pend_delay;
    hold_lvl_t     pend_lvl;

    assign acc     = cmd_valid && cmd_en;
    assign cmd_lvl = cmd_fill ? LVL_FILL : LVL_BREAK;

    tx_pause_cnt #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    tx_pause_pend #(.DW(DW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (pend_cap),
        .take      (pend_take),
        .cap_delay (cmd_delay),
        .cap_lvl   (cmd_lvl),
        .full      (pend_full),
        .p_delay   (pend_delay),
        .p_lvl     (pend_lvl)
    );

    tx_pause_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .cmd_delay  (cmd_delay),
        .cmd_lvl    (cmd_lvl),
        .tick       (tick),
        .cnt        (cnt),
        .cnt_last   (cnt_last),
        .pend_full  (pend_full),
        .pend_delay (pend_delay),
        .pend_lvl   (pend_lvl),
        .tx_bit     (tx_bit),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .cnt_dec    (cnt_dec),
        .pend_cap   (pend_cap),
        .pend_take  (pend_take),
        .hold       (tx_stall),
        .line       (line_out)
    );

    // R1: with commands disabled, an idle controller stays idle
    a_r1_en_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_stall && !cmd_en) |=> !tx_stall);

    // R11: removing the enable never ends a delay that has not expired
    a_r11_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stall && !cmd_en && !(tick && cnt_last)) |=> tx_stall);

endmodule

// File: tb/tx_pause_ctrl_bench.sv
module tx_pause_ctrl_bench;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [DW-1:0] cmd_delay = '0;
    logic          cmd_fill = 1'b0;
    logic          tick = 1'b0;
    logic          tx_bit = 1'b0;
    logic          line_out, tx_stall;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tx_pause_ctrl #(.DW(DW)) u_tx_pause_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_en    (cmd_en),
        .cmd_valid (cmd_valid),
        .cmd_delay (cmd_delay),
        .cmd_fill  (cmd_fill),
        .tick      (tick),
        .tx_bit    (tx_bit),
        .line_out  (line_out),
        .tx_stall  (tx_stall)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One scenario: command A at cycle 0, optional B and C later, optional enable drop.
    task automatic run_case(input string tag, input bit en0, input int da, input bit la,
                            input int per, input int bcyc, input int db, input bit lb,
                            input int ccyc, input int dc, input int endrop);
        int  ticks = 0;
        int  total = 0;
        bit  b_acc = 1'b0;
        bit  en_cur = en0;
        bit  exp_stall;
        bit  exp_line;
        int  ncyc = (da + db + dc) * per + 6;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            tx_bit    = ((c * 7) >> 1) & 1;
            cmd_valid = 1'b0;
            tick      = 1'b0;
            if (c == endrop) en_cur = 1'b0;
            cmd_en = en_cur;
            #1;
            exp_stall = (ticks < total);
            if (exp_stall) exp_line = (ticks < da) ? la : lb;
            else           exp_line = tx_bit;
            if (c == 1 && exp_stall) check("R2", tx_stall, exp_stall);
            else                     check(tag, tx_stall, exp_stall);
            check(exp_stall ? "R4" : "R9", line_out, exp_line);
            // drive this cycle's command and tick; model the next edge
            tick = ((c % per) == 0);
            if (c == 0) begin
                cmd_valid = 1'b1; cmd_delay = DW'(da); cmd_fill = la;
                if (en_cur) total = da;
            end else if (c == bcyc) begin
                cmd_valid = 1'b1; cmd_delay = DW'(db); cmd_fill = lb;
                if (en_cur && exp_stall && !b_acc) begin
                    b_acc = 1'b1;
                    total = total + db;
                end
            end else if (c == ccyc) begin
                // issued while B waits: must be dropped (R8)
                cmd_valid = 1'b1; cmd_delay = DW'(dc); cmd_fill = 1'b0;
            end
            if (tick && exp_stall) ticks++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        tick      = 1'b0;
        cmd_en    = 1'b0;
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        tx_bit = 1'b1; #1;
        check("R10", tx_stall, 1'b0);
        check("R10", line_out, 1'b1);
        rst_n = 1'b1;
        @(negedge clk); tx_bit = 1'b0; #1;
        check("R10", tx_stall, 1'b0);
        check("R10", line_out, 1'b0);

        // R3/R5/R6 sweep: delay 0..6, both levels, tick every 1..3 cycles
        for (int d = 0; d <= 6; d++) begin
            for (int l = 0; l <= 1; l++) begin
                for (int p = 1; p <= 3; p++) begin
                    run_case((d == 0) ? "R6" : ((p == 1) ? "R3" : "R5"),
                             1'b1, d, l[0], p, -1, 0, 1'b0, -1, 0, -1);
                end
            end
        end

        // R1: disabled commands ignored
        run_case("R1", 1'b0, 5, 1'b0, 1, -1, 0, 1'b0, -1, 0, -1);
        run_case("R1", 1'b0, 3, 1'b1, 2, -1, 0, 1'b0, -1, 0, -1);

        // R7: waiting command chains without a gap, with its own level
        run_case("R7", 1'b1, 3, 1'b1, 1, 2, 2, 1'b0, -1, 0, -1);
        run_case("R7", 1'b1, 4, 1'b0, 2, 1, 3, 1'b1, -1, 0, -1);
        run_case("R7", 1'b1, 2, 1'b1, 1, 2, 3, 1'b0, -1, 0, -1);
        run_case("R7", 1'b1, 3, 1'b0, 1, 1, 0, 1'b1, -1, 0, -1);

        // R8: third command while one waits is dropped
        run_case("R8", 1'b1, 4, 1'b1, 1, 1, 2, 1'b0, 2, 5, -1);

        // R11: enable dropped mid-delay; later command ignored (R1)
        run_case("R11", 1'b1, 5, 1'b0, 1, 3, 4, 1'b1, -1, 0, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule